// File: doc/BRIEF.md
# Algebraic AES Byte Substitution Unit

This block replaces one byte with its AES substitution value, or with the inverse substitution value, using finite-field arithmetic in logic rather than a stored table. A mode input chooses the direction. Forward substitution takes the multiplicative inverse of the byte in GF(2^8) and then passes it through an affine map over GF(2). Inverse substitution first undoes the affine map and then takes the multiplicative inverse. Both directions share one field inverter.

The unit is purely combinational and has no clock or reset. It is meant to be placed in the round datapath of a cipher core, once for each state byte or once for each key-schedule byte. A parameter selects one of two inverter structures with the same function. Both compute x^254, which is the field inverse for every nonzero byte and gives 0x00 for 0x00.

Top module: `gf_sbox_unit`

## Requirements
- R1: With `inv_sel` = 0 (forward), `dout` gives the substitution value of `din` in the same cycle; spot values are S(0x00)=0x63, S(0x53)=0xED, S(0x01)=0x7C, S(0x10)=0xCA, S(0xFF)=0x16.
- R2: In forward mode, `dout` equals A(inv(`din`)) for all 256 inputs. Here inv is the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (0x11B), with inv(0)=0, and A sets bit i to b_i ^ b_(i+4) ^ b_(i+5) ^ b_(i+6) ^ b_(i+7) ^ c_i, indices mod 8, c = 0x63.
- R3: With `inv_sel` = 1 (inverse), `dout` undoes forward substitution for all 256 values: InvS(S(x)) = x.
- R4: In forward mode, no input byte maps to itself.
- R5: The zero byte passes through inversion unchanged in both directions: forward S(0x00)=0x63 and inverse InvS(0x63)=0x00. The inverse affine map sets bit i to b_(i+2) ^ b_(i+5) ^ b_(i+7) ^ d_i with d = 0x05, so InvS(0x00)=0x52.
- R6: The two inverter structures (parameter `INV_ARCH` = 0, addition chain; 1, product of squares) give identical `dout` for every input in both modes.
- R7: Changing only `inv_sel` with `din` held selects the other direction in the same cycle; for `din`=0x53 the output is 0xED forward and 0x50 inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Byte to substitute |
| inv_sel | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| dout | output | 8 | Substituted byte |

## Verification
The bench builds the unit twice: once with `INV_ARCH` = 0, the default addition-chain inverter, and once with `INV_ARCH` = 1, the product-of-squares inverter. Both instances see the same stimulus. This makes every input in both modes a point where the two inverter structures are compared, so a fault in a squaring stage or a multiplier of either variant shows up. The reference model finds each inverse by exhaustive search and forms the affine map with byte rotations, so the all-byte sweeps check the direction mux, the ordering of affine and inversion, and the zero case against a model built independently of the RTL.

// File: rtl/gf_sbox_pkg.sv
// Package: shared field constants and GF(2^8) arithmetic helpers.
// Assumes the field is defined by x^8+x^4+x^3+x+1.
package gf_sbox_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [7:0]  RED_POLY = 8'h1B;   // low byte of 0x11B
    localparam logic [7:0]  FWD_CONST = 8'h63;
    localparam logic [7:0]  INV_CONST = 8'h05;

    // Multiply two field elements by shift-and-add with modular reduction.
    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < BYTE_W; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? RED_POLY : 8'h00);
        end
        return acc;
    endfunction

    // Square a field element.
    function automatic logic [BYTE_W-1:0] gf_sq(input logic [BYTE_W-1:0] a);
        return gf_mul(a, a);
    endfunction

endpackage

// File: rtl/gf_inverter.sv
// Module: gf_inverter
// Computes x^254 in GF(2^8): the multiplicative inverse for nonzero x,
// and 0 for x = 0. INV_ARCH picks the structure:
//   0 = addition chain (4 multipliers, 7 squarers)
//   1 = product of x^2, x^4, ..., x^128 (6 multipliers, 7 squarers)
// Purely combinational; assumes the package field polynomial.
module gf_inverter
    import gf_sbox_pkg::*;
#(
    parameter int INV_ARCH = 0
) (
    input  logic [BYTE_W-1:0] x,
    output logic [BYTE_W-1:0] y
);

    localparam int NSQ = BYTE_W - 1;   // number of repeated squarings

    generate
        if (INV_ARCH == 0) begin : g_chain
            logic [BYTE_W-1:0] p2, p3, p6, p7, p14, p15, p30, p60, p120, p127;

            // Addition chain 1,2,3,6,7,14,15,30,60,120,127,254.
            always_comb begin
                p2   = gf_sq(x);
                p3   = gf_mul(p2, x);
                p6   = gf_sq(p3);
                p7   = gf_mul(p6, x);
                p14  = gf_sq(p7);
                p15  = gf_mul(p14, x);
                p30  = gf_sq(p15);
                p60  = gf_sq(p30);
                p120 = gf_sq(p60);
                p127 = gf_mul(p120, p7);
                y    = gf_sq(p127);
            end
        end else begin : g_squares
            logic [BYTE_W-1:0] pw   [NSQ+1];
            logic [BYTE_W-1:0] prod [NSQ+1];

            assign pw[0]   = x;
            assign prod[0] = 8'h01;

            for (genvar k = 1; k <= NSQ; k++) begin : g_stage
                // Stage k: form x^(2^k) and fold it into the running product.
                assign pw[k]   = gf_sq(pw[k-1]);
                assign prod[k] = gf_mul(prod[k-1], pw[k]);
            end

            assign y = prod[NSQ];
        end
    endgenerate

endmodule

// File: rtl/gf_affine.sv
// Module: gf_affine
// Bit-matrix multiply over GF(2) plus a constant. INVERSE selects the map:
//   0 = forward: bit i = b[i]^b[i+4]^b[i+5]^b[i+6]^b[i+7]^0x63[i]
//   1 = inverse: bit i = b[i+2]^b[i+5]^b[i+7]^0x05[i]
// Indices wrap modulo the byte width. Purely combinational.
module gf_affine
    import gf_sbox_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BYTE_W-1:0] a,
    output logic [BYTE_W-1:0] b
);

    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            localparam int I2 = (i + 2) % BYTE_W;
            localparam int I4 = (i + 4) % BYTE_W;
            localparam int I5 = (i + 5) % BYTE_W;
            localparam int I6 = (i + 6) % BYTE_W;
            localparam int I7 = (i + 7) % BYTE_W;
            if (!INVERSE) begin : g_fwd
                // Forward row i of the circulant matrix.
                assign b[i] = a[i] ^ a[I4] ^ a[I5] ^ a[I6] ^ a[I7] ^ FWD_CONST[i];
            end else begin : g_inv
                // Inverse row i of the circulant matrix.
                assign b[i] = a[I2] ^ a[I5] ^ a[I7] ^ INV_CONST[i];
            end
        end
    endgenerate

endmodule

// File: rtl/gf_sbox_unit.sv
// Module: gf_sbox_unit (top)
// Forward or inverse AES byte substitution derived algebraically.
// Forward: affine(inv(din)). Inverse: inv(inv_affine(din)).
// One inverter is shared; the mode bit steers its input and output.
// Purely combinational: no clock, no reset, no state.
module gf_sbox_unit
    import gf_sbox_pkg::*;
#(
    parameter int INV_ARCH = 0
) (
    input  logic [7:0] din,
    input  logic       inv_sel,
    output logic [7:0] dout
);

    logic [BYTE_W-1:0] pre_inv;
    logic [BYTE_W-1:0] unaff;
    logic [BYTE_W-1:0] inv_out;
    logic [BYTE_W-1:0] aff_out;

    gf_affine #(.INVERSE(1'b1)) u_unaffine (
        .a (din),
        .b (unaff)
    );

    // Inverter input: raw byte forward, un-affined byte inverse.
    always_comb pre_inv = inv_sel ? unaff : din;

    gf_inverter #(.INV_ARCH(INV_ARCH)) u_inv (
        .x (pre_inv),
        .y (inv_out)
    );

    gf_affine #(.INVERSE(1'b0)) u_affine (
        .a (inv_out),
        .b (aff_out)
    );

    // Output: affine of the inverse forward, the inverse itself otherwise.
    always_comb dout = inv_sel ? inv_out : aff_out;

endmodule

// File: rtl/gf_sbox_unit_chk.sv
// Module: gf_sbox_unit_chk
// Property checker bound to gf_sbox_unit. The unit has no clock, so the
// checks are immediate assertions evaluated whenever the ports change.
module gf_sbox_unit_chk (
    input logic [7:0] din,
    input logic       inv_sel,
    input logic [7:0] dout
);

    // Evaluate port relations on every change of the ports.
    always_comb begin
        // R4
        fwd_no_fixed_point_chk: assert (inv_sel || dout != din);
        // R5
        fwd_zero_chk: assert (inv_sel || din != 8'h00 || dout == 8'h63);
        // R5
        inv_zero_chk: assert (!inv_sel || din != 8'h63 || dout == 8'h00);
        // R1
        fwd_spot_chk: assert (inv_sel || din != 8'h53 || dout == 8'hED);
        // R7
        inv_spot_chk: assert (!inv_sel || din != 8'h53 || dout == 8'h50);
    end

endmodule

bind gf_sbox_unit gf_sbox_unit_chk u_chk (
    .din     (din),
    .inv_sel (inv_sel),
    .dout    (dout)
);

// File: tb/gf_sbox_unit_test.sv
// Directed bench for gf_sbox_unit; two instances cover both inverter variants.
module gf_sbox_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       inv_sel = 1'b0;
    logic [7:0] dout;
    logic [7:0] dout_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    gf_sbox_unit #(.INV_ARCH(0)) uut (
        .din (din), .inv_sel (inv_sel), .dout (dout)
    );

    gf_sbox_unit #(.INV_ARCH(1)) uut_b (
        .din (din), .inv_sel (inv_sel), .dout (dout_b)
    );

    // Reference multiply: Horner form, most significant bit of b first.
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        r = 8'h00;
        for (int k = 7; k >= 0; k--) begin
            r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1B : 8'h00);
            if (b[k]) r = r ^ a;
        end
        return r;
    endfunction

    // Reference inverse by exhaustive search.
    function automatic logic [7:0] ref_inv(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h00;
        for (int c = 1; c < 256; c++)
            if (ref_mul(a, 8'(c)) == 8'h01) r = 8'(c);
        return r;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    // Reference forward substitution through byte rotations.
    function automatic logic [7:0] ref_s(input logic [7:0] a);
        logic [7:0] q;
        q = ref_inv(a);
        return q ^ rotl(q, 1) ^ rotl(q, 2) ^ rotl(q, 3) ^ rotl(q, 4) ^ 8'h63;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s din=%02h inv_sel=%0b actual=%02h expected=%02h",
                     req, din, inv_sel, act, exp);
        end
    endtask

    // Drive after a rising edge, sample at the following falling edge.
    task automatic apply(input logic [7:0] v, input logic m);
        @(posedge clk);
        #1;
        din = v;
        inv_sel = m;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        apply(8'h00, 1'b0);
        check("R5 forward zero after reset", dout, 8'h63);
    endtask

    task automatic t_spot_values;
        apply(8'h53, 1'b0); check("R1", dout, 8'hED);
        apply(8'h01, 1'b0); check("R1", dout, 8'h7C);
        apply(8'h10, 1'b0); check("R1", dout, 8'hCA);
        apply(8'hFF, 1'b0); check("R1", dout, 8'h16);
    endtask

    task automatic t_forward_sweep;
        for (int v = 0; v < 256; v++) begin
            apply(8'(v), 1'b0);
            check("R2 forward sweep", dout, ref_s(8'(v)));
            checks++;
            if (dout == 8'(v)) begin
                errors++;
                $display("FAIL R4 fixed point actual=%02h expected!=%02h", dout, 8'(v));
            end
            check("R6 forward variant match", dout_b, dout);
        end
    endtask

    task automatic t_inverse_sweep;
        for (int v = 0; v < 256; v++) begin
            apply(ref_s(8'(v)), 1'b1);
            check("R3 inverse round trip", dout, 8'(v));
            check("R6 inverse variant match", dout_b, 8'(v));
        end
    endtask

    task automatic t_zero_inverse;
        apply(8'h63, 1'b1); check("R5 inverse of 0x63", dout, 8'h00);
        apply(8'h00, 1'b1); check("R5 inverse of zero", dout, 8'h52);
    endtask

    task automatic t_mode_toggle;
        apply(8'h53, 1'b1); check("R7 inverse side", dout, 8'h50);
        apply(8'h53, 1'b0); check("R7 forward side", dout, 8'hED);
        apply(8'h53, 1'b1); check("R7 back to inverse", dout, 8'h50);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_spot_values();
        t_forward_sweep();
        t_inverse_sweep();
        t_zero_inverse();
        t_mode_toggle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule